// File: doc/BRIEF.md
# Instruction Decoder with Immediate Generation

This block turns one 32-bit instruction word of the base integer instruction set into everything a simple pipeline needs to execute it. It splits out the register indices and function fields, builds the sign-extended 32-bit immediate in the shape the instruction format calls for, and produces the control signals that steer the register file, the ALU operands, the data memory, the program counter and the write-back multiplexer. The block has no clock and no state. The word goes in and the decoded result comes out in the same cycle.

The decoder covers register-register and register-immediate compute, the two upper-immediate forms (load upper and add upper to PC), word loads, word stores, the six conditional branches, and the two jump-and-link forms. Byte and halfword memory accesses, fences and system instructions are not decoded. Any of these, or any other word outside the subset, raises the illegal flag. When the flag is set, every enable goes low, so an illegal word cannot change architectural state.

Top module: `instr_decoder`

## Requirements
- R1: For every word, rd_o = instr_i[11:7], rs1_o = instr_i[19:15], rs2_o = instr_i[24:20], funct3_o = instr_i[14:12] and funct7_o = instr_i[31:25].
- R2: The recognised opcodes (instr_i[6:0]) are 0110011 reg-reg, 0010011 reg-imm, 0110111 load-upper, 0010111 add-upper-PC, 0000011 load, 0100011 store, 1100011 branch, 1101111 jump-and-link and 1100111 jump-and-link-register. Any other opcode sets illegal_o and forces reg_we_o, mem_rd_o, mem_wr_o, branch_o, jump_o, jump_reg_o, alu_src_imm_o and op_a_pc_o low, wb_sel_o to 00 and imm_o to 0.
- R3: For reg-imm, load and jump-and-link-register words, imm_o is instr_i[31:20] sign-extended from bit 31.
- R4: For store words, imm_o is {instr_i[31:25], instr_i[11:7]} sign-extended.
- R5: For branch words, imm_o is {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 0} sign-extended, so bit 0 is always 0.
- R6: For jump-and-link words, imm_o is {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 0} sign-extended, so bit 0 is always 0.
- R7: For load-upper and add-upper-PC words, imm_o is {instr_i[31:12], 12'b0}.
- R8: wb_sel_o is 00 for ALU, 01 for memory, 10 for PC+4 and 11 for upper immediate. Reg-reg, reg-imm and add-upper-PC select 00, load selects 01, both jumps select 10, and load-upper selects 11. reg_we_o is high for these classes and is never high for store or branch words.
- R9: mem_rd_o is high only for legal loads and mem_wr_o only for legal stores. The two are never high together.
- R10: branch_o is high only for legal branch words. jump_o is high for both jump forms. jump_reg_o is high only for jump-and-link-register.
- R11: alu_src_imm_o is high for reg-imm, both upper forms, load, store and both jumps, and low for reg-reg and branch. op_a_pc_o is high only for add-upper-PC and jump-and-link.
- R12: Within a recognised opcode, these function codes are illegal and behave as in R2: a load or store with funct3 other than 010, jump-and-link-register with funct3 other than 000, a branch with funct3 010 or 011, a reg-reg word whose funct7 is neither 0000000 nor 0100000 or is 0100000 with funct3 other than 000 or 101, a reg-imm funct3 001 with funct7 other than 0000000, and a reg-imm funct3 101 with funct7 other than 0000000 or 0100000.
- R13: For reg-reg words, imm_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| funct3_o | output | 3 | Minor function code |
| funct7_o | output | 7 | Upper function code |
| imm_o | output | 32 | Sign-extended immediate for the format |
| reg_we_o | output | 1 | Register file write enable |
| alu_src_imm_o | output | 1 | ALU operand B takes the immediate |
| op_a_pc_o | output | 1 | ALU operand A takes the PC |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| jump_reg_o | output | 1 | Jump target is register-relative |
| wb_sel_o | output | 2 | Write-back source select |
| illegal_o | output | 1 | Word is outside the decoded subset |

## Verification
The block has no state. A wrong decision inside it shows up on the ports within the same cycle as the word that triggers it: a wrong immediate shape, a wrong enable, or an illegal word that is let through. The bench encodes each format from a chosen offset or constant and compares the result against the sign-extended value it intended, so a bit that is swapped or left out shows up on the ports directly. It also steps through the function-code corners that separate legal words from illegal ones.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;

    localparam int ILEN     = 32;
    localparam int REG_AW   = 5;
    localparam int OPC_W    = 7;
    localparam int F3_W     = 3;
    localparam int F7_W     = 7;
    localparam int WB_W     = 2;
    localparam int FIELD_LO = 7;

    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

    localparam logic [F3_W-1:0] F3_WORD   = 3'b010;
    localparam logic [F3_W-1:0] F3_ADDSUB = 3'b000;
    localparam logic [F3_W-1:0] F3_SLL    = 3'b001;
    localparam logic [F3_W-1:0] F3_SR     = 3'b101;
    localparam logic [F7_W-1:0] F7_BASE   = 7'b0000000;
    localparam logic [F7_W-1:0] F7_ALT    = 7'b0100000;

    typedef enum logic [WB_W-1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_PC4  = 2'b10,
        WB_UIMM = 2'b11
    } wb_sel_e;

    typedef enum logic [2:0] {
        IMM_NONE,
        IMM_I,
        IMM_S,
        IMM_B,
        IMM_J,
        IMM_U
    } imm_kind_e;

    typedef struct packed {
        logic    reg_we;
        logic    alu_src_imm;
        logic    op_a_pc;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        logic    jump;
        logic    jump_reg;
        wb_sel_e wb_sel;
        logic    illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        reg_we: 1'b0, alu_src_imm: 1'b0, op_a_pc: 1'b0, mem_rd: 1'b0,
        mem_wr: 1'b0, branch: 1'b0, jump: 1'b0, jump_reg: 1'b0,
        wb_sel: WB_ALU, illegal: 1'b0
    };

    // Body of the word above the opcode: bits [31:7].
    localparam int BODY_W = ILEN - FIELD_LO;

    function automatic logic [ILEN-1:0] imm_i_f(input logic [ILEN-1:0] w);
        return {{(ILEN-12){w[31]}}, w[31:20]};
    endfunction

    function automatic logic [ILEN-1:0] imm_s_f(input logic [ILEN-1:0] w);
        return {{(ILEN-12){w[31]}}, w[31:25], w[11:7]};
    endfunction

    function automatic logic [ILEN-1:0] imm_b_f(input logic [ILEN-1:0] w);
        return {{(ILEN-13){w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic [ILEN-1:0] imm_j_f(input logic [ILEN-1:0] w);
        return {{(ILEN-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    function automatic logic [ILEN-1:0] imm_u_f(input logic [ILEN-1:0] w);
        return {w[31:12], 12'b0};
    endfunction

    function automatic logic op_legal_f(input logic [F3_W-1:0] f3,
                                        input logic [F7_W-1:0] f7);
        return (f7 == F7_BASE) ||
               ((f7 == F7_ALT) && ((f3 == F3_ADDSUB) || (f3 == F3_SR)));
    endfunction

    function automatic logic opimm_legal_f(input logic [F3_W-1:0] f3,
                                           input logic [F7_W-1:0] f7);
        logic ok;
        case (f3)
            F3_SLL:  ok = (f7 == F7_BASE);
            F3_SR:   ok = (f7 == F7_BASE) || (f7 == F7_ALT);
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic branch_legal_f(input logic [F3_W-1:0] f3);
        return (f3 != 3'b010) && (f3 != 3'b011);
    endfunction

endpackage

// File: rtl/dec_fields.sv
module dec_fields
    import instr_decoder_pkg::*;
(
    input  logic [BODY_W-1:0] body_i,
    output logic [REG_AW-1:0] rd_o,
    output logic [REG_AW-1:0] rs1_o,
    output logic [REG_AW-1:0] rs2_o,
    output logic [F3_W-1:0]   funct3_o,
    output logic [F7_W-1:0]   funct7_o
);
    // Positions in the full word, shifted down by the opcode width.
    localparam int RD_LO  = 7  - FIELD_LO;
    localparam int F3_LO  = 12 - FIELD_LO;
    localparam int RS1_LO = 15 - FIELD_LO;
    localparam int RS2_LO = 20 - FIELD_LO;
    localparam int F7_LO  = 25 - FIELD_LO;

    always_comb begin
        rd_o     = body_i[RD_LO  +: REG_AW];
        funct3_o = body_i[F3_LO  +: F3_W];
        rs1_o    = body_i[RS1_LO +: REG_AW];
        rs2_o    = body_i[RS2_LO +: REG_AW];
        funct7_o = body_i[F7_LO  +: F7_W];
    end
endmodule

// File: rtl/dec_immgen.sv
module dec_immgen
    import instr_decoder_pkg::*;
(
    input  logic [BODY_W-1:0] body_i,
    input  imm_kind_e         kind_i,
    output logic [ILEN-1:0]   imm_o
);
    logic [ILEN-1:0] word;

    // The low opcode bits take no part in any immediate.
    assign word = {body_i, {FIELD_LO{1'b0}}};

    always_comb begin
        case (kind_i)
            IMM_I:   imm_o = imm_i_f(word);
            IMM_S:   imm_o = imm_s_f(word);
            IMM_B:   imm_o = imm_b_f(word);
            IMM_J:   imm_o = imm_j_f(word);
            IMM_U:   imm_o = imm_u_f(word);
            default: imm_o = '0;
        endcase
    end
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
    import instr_decoder_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [F3_W-1:0]  funct3_i,
    input  logic [F7_W-1:0]  funct7_i,
    output ctrl_t            ctrl_o,
    output imm_kind_e        kind_o
);
    ctrl_t     c;
    imm_kind_e k;
    logic      legal;

    always_comb begin
        c     = CTRL_IDLE;
        k     = IMM_NONE;
        legal = 1'b1;
        case (opcode_i)
            OPC_OP: begin
                legal    = op_legal_f(funct3_i, funct7_i);
                c.reg_we = 1'b1;
                c.wb_sel = WB_ALU;
            end
            OPC_OPIMM: begin
                legal         = opimm_legal_f(funct3_i, funct7_i);
                c.reg_we      = 1'b1;
                c.alu_src_imm = 1'b1;
                c.wb_sel      = WB_ALU;
                k             = IMM_I;
            end
            OPC_LUI: begin
                c.reg_we      = 1'b1;
                c.alu_src_imm = 1'b1;
                c.wb_sel      = WB_UIMM;
                k             = IMM_U;
            end
            OPC_AUIPC: begin
                c.reg_we      = 1'b1;
                c.alu_src_imm = 1'b1;
                c.op_a_pc     = 1'b1;
                c.wb_sel      = WB_ALU;
                k             = IMM_U;
            end
            OPC_LOAD: begin
                legal         = (funct3_i == F3_WORD);
                c.reg_we      = 1'b1;
                c.alu_src_imm = 1'b1;
                c.mem_rd      = 1'b1;
                c.wb_sel      = WB_MEM;
                k             = IMM_I;
            end
            OPC_STORE: begin
                legal         = (funct3_i == F3_WORD);
                c.alu_src_imm = 1'b1;
                c.mem_wr      = 1'b1;
                k             = IMM_S;
            end
            OPC_BRANCH: begin
                legal    = branch_legal_f(funct3_i);
                c.branch = 1'b1;
                k        = IMM_B;
            end
            OPC_JAL: begin
                c.reg_we      = 1'b1;
                c.alu_src_imm = 1'b1;
                c.op_a_pc     = 1'b1;
                c.jump        = 1'b1;
                c.wb_sel      = WB_PC4;
                k             = IMM_J;
            end
            OPC_JALR: begin
                legal         = (funct3_i == F3_ADDSUB);
                c.reg_we      = 1'b1;
                c.alu_src_imm = 1'b1;
                c.jump        = 1'b1;
                c.jump_reg    = 1'b1;
                c.wb_sel      = WB_PC4;
                k             = IMM_I;
            end
            default: legal = 1'b0;
        endcase

        if (!legal) begin
            c         = CTRL_IDLE;
            c.illegal = 1'b1;
            k         = IMM_NONE;
        end
    end

    assign ctrl_o = c;
    assign kind_o = k;
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import instr_decoder_pkg::*;
(
    input  logic [31:0] instr_i,
    output logic [4:0]  rd_o,
    output logic [4:0]  rs1_o,
    output logic [4:0]  rs2_o,
    output logic [2:0]  funct3_o,
    output logic [6:0]  funct7_o,
    output logic [31:0] imm_o,
    output logic        reg_we_o,
    output logic        alu_src_imm_o,
    output logic        op_a_pc_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        branch_o,
    output logic        jump_o,
    output logic        jump_reg_o,
    output logic [1:0]  wb_sel_o,
    output logic        illegal_o
);
    ctrl_t     ctrl;
    imm_kind_e kind;

    dec_fields u_fields (
        .body_i   (instr_i[ILEN-1:FIELD_LO]),
        .rd_o     (rd_o),
        .rs1_o    (rs1_o),
        .rs2_o    (rs2_o),
        .funct3_o (funct3_o),
        .funct7_o (funct7_o)
    );

    dec_ctrl u_ctrl (
        .opcode_i (instr_i[OPC_W-1:0]),
        .funct3_i (funct3_o),
        .funct7_i (funct7_o),
        .ctrl_o   (ctrl),
        .kind_o   (kind)
    );

    dec_immgen u_imm (
        .body_i (instr_i[ILEN-1:FIELD_LO]),
        .kind_i (kind),
        .imm_o  (imm_o)
    );

    always_comb begin
        reg_we_o      = ctrl.reg_we;
        alu_src_imm_o = ctrl.alu_src_imm;
        op_a_pc_o     = ctrl.op_a_pc;
        mem_rd_o      = ctrl.mem_rd;
        mem_wr_o      = ctrl.mem_wr;
        branch_o      = ctrl.branch;
        jump_o        = ctrl.jump;
        jump_reg_o    = ctrl.jump_reg;
        wb_sel_o      = ctrl.wb_sel;
        illegal_o     = ctrl.illegal;
    end
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
    input logic [31:0] instr_i,
    input logic [31:0] imm_o,
    input logic        reg_we_o,
    input logic        alu_src_imm_o,
    input logic        op_a_pc_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic        branch_o,
    input logic        jump_o,
    input logic        jump_reg_o,
    input logic [1:0]  wb_sel_o,
    input logic        illegal_o
);
    always_comb begin
        // R2
        illegal_quiet_chk: assert (!illegal_o ||
            !(reg_we_o | mem_rd_o | mem_wr_o | branch_o | jump_o | jump_reg_o |
              alu_src_imm_o | op_a_pc_o) && imm_o == 32'd0)
            else $error("illegal word left an enable or immediate set");
        // R2
        legal_low_bits_chk: assert (illegal_o || instr_i[1:0] == 2'b11)
            else $error("accepted word with low opcode bits not 11");
        // R8
        no_we_store_branch_chk: assert (!(mem_wr_o || branch_o) || !reg_we_o)
            else $error("store or branch requested a register write");
        // R9
        mem_exclusive_chk: assert (!(mem_rd_o && mem_wr_o))
            else $error("memory read and write together");
        // R8
        mem_wb_pair_chk: assert ((wb_sel_o == 2'b01) == mem_rd_o)
            else $error("memory write-back select disagrees with read");
        // R10
        jreg_implies_jump_chk: assert (!jump_reg_o || jump_o)
            else $error("register jump without jump");
        // R5
        branch_even_chk: assert (!branch_o || imm_o[0] == 1'b0)
            else $error("branch offset odd");
        // R6
        jump_even_chk: assert (!(jump_o && !jump_reg_o) || imm_o[0] == 1'b0)
            else $error("jump offset odd");
        // R10
        single_flow_chk: assert ($countones({branch_o, jump_o, mem_rd_o, mem_wr_o}) <= 1)
            else $error("more than one instruction class active");
    end
endmodule

bind instr_decoder instr_decoder_chk u_chk (.*);

// File: tb/instr_decoder_tb.sv
`timescale 1ns/1ps
module instr_decoder_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [31:0] instr_i = 32'd0;
    logic [4:0]  rd_o, rs1_o, rs2_o;
    logic [2:0]  funct3_o;
    logic [6:0]  funct7_o;
    logic [31:0] imm_o;
    logic        reg_we_o, alu_src_imm_o, op_a_pc_o, mem_rd_o, mem_wr_o;
    logic        branch_o, jump_o, jump_reg_o, illegal_o;
    logic [1:0]  wb_sel_o;

    int checks = 0;
    int errors = 0;

    instr_decoder u_dut (.*);

    // control vector: we, asrc, apc, mrd, mwr, br, j, jr, wb[1:0], ill
    function automatic logic [10:0] ctl_now();
        return {reg_we_o, alu_src_imm_o, op_a_pc_o, mem_rd_o, mem_wr_o,
                branch_o, jump_o, jump_reg_o, wb_sel_o, illegal_o};
    endfunction

    localparam logic [10:0] C_ILL = 11'b00000000_00_1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr_i = w;
        #1;
    endtask

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f3);
        return {off[12], off[10:5], 5'd3, 5'd4, f3, off[4:1], off[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    task automatic t_reset;
        // word 0 has opcode 0000000, which is not in the subset
        chk("R2", "reset ctrl", {21'd0, ctl_now()}, {21'd0, C_ILL});
        chk("R2", "reset imm", imm_o, 32'd0);
    endtask

    task automatic t_fields;
        apply(32'b1010101_10011_01110_110_11001_0110011);
        chk("R1", "rd", {27'd0, rd_o}, 32'd25);
        chk("R1", "rs1", {27'd0, rs1_o}, 32'd14);
        chk("R1", "rs2", {27'd0, rs2_o}, 32'd19);
        chk("R1", "funct3", {29'd0, funct3_o}, 32'd6);
        chk("R1", "funct7", {25'd0, funct7_o}, 32'h55);
    endtask

    task automatic t_regreg;
        apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3));
        chk("R8", "sub ctrl", {21'd0, ctl_now()}, {21'd0, 11'b10000000_00_0});
        chk("R13", "sub imm", imm_o, 32'd0);
        chk("R11", "sub asrc", {31'd0, alu_src_imm_o}, 32'd0);
        apply(enc_r(7'b0000000, 5'd31, 5'd30, 3'b111, 5'd29));
        chk("R8", "and ctrl", {21'd0, ctl_now()}, {21'd0, 11'b10000000_00_0});
        chk("R13", "and imm", imm_o, 32'd0);
    endtask

    task automatic t_regimm;
        apply(enc_i(12'h800, 5'd1, 3'b000, 5'd2, 7'b0010011));
        chk("R3", "addi neg imm", imm_o, 32'hFFFFF800);
        chk("R11", "addi ctrl", {21'd0, ctl_now()}, {21'd0, 11'b11000000_00_0});
        apply(enc_i(12'h7FF, 5'd1, 3'b100, 5'd2, 7'b0010011));
        chk("R3", "xori pos imm", imm_o, 32'h000007FF);
        apply(enc_i({7'b0100000, 5'd9}, 5'd1, 3'b101, 5'd2, 7'b0010011));
        chk("R12", "srai legal", {31'd0, illegal_o}, 32'd0);
        chk("R3", "srai imm", imm_o, 32'h00000409);
    endtask

    task automatic t_mem;
        apply(enc_i(12'hFFC, 5'd8, 3'b010, 5'd9, 7'b0000011));
        chk("R9", "lw ctrl", {21'd0, ctl_now()}, {21'd0, 11'b11010000_01_0});
        chk("R3", "lw imm", imm_o, 32'hFFFFFFFC);
        apply(enc_s(12'h923, 5'd7, 5'd8, 3'b010));
        chk("R9", "sw ctrl", {21'd0, ctl_now()}, {21'd0, 11'b01001000_00_0});
        chk("R8", "sw no we", {31'd0, reg_we_o}, 32'd0);
        chk("R4", "sw neg imm", imm_o, 32'hFFFFF923);
        apply(enc_s(12'h41F, 5'd7, 5'd8, 3'b010));
        chk("R4", "sw pos imm", imm_o, 32'h0000041F);
    endtask

    task automatic t_branch;
        apply(enc_b(13'h1000, 3'b000));
        chk("R5", "beq min", imm_o, 32'hFFFFF000);
        chk("R10", "beq ctrl", {21'd0, ctl_now()}, {21'd0, 11'b00000100_00_0});
        apply(enc_b(13'h0FFE, 3'b111));
        chk("R5", "bgeu max", imm_o, 32'h00000FFE);
        apply(enc_b(13'h1FFE, 3'b100));
        chk("R5", "blt -2", imm_o, 32'hFFFFFFFE);
        chk("R8", "blt no we", {31'd0, reg_we_o}, 32'd0);
        apply(enc_b(13'h0AAA, 3'b001));
        chk("R5", "bne mixed", imm_o, 32'h00000AAA);
    endtask

    task automatic t_jumps;
        apply(enc_j(21'h100000, 5'd1));
        chk("R6", "jal min", imm_o, 32'hFFF00000);
        chk("R10", "jal ctrl", {21'd0, ctl_now()}, {21'd0, 11'b11100010_10_0});
        apply(enc_j(21'h0FFFFE, 5'd1));
        chk("R6", "jal max", imm_o, 32'h000FFFFE);
        apply(enc_j(21'h1FFFFE, 5'd0));
        chk("R6", "jal -2", imm_o, 32'hFFFFFFFE);
        apply(enc_j(21'h0A5A4, 5'd0));
        chk("R6", "jal mixed", imm_o, 32'h000A5A4);
        apply(enc_i(12'hFFF, 5'd5, 3'b000, 5'd1, 7'b1100111));
        chk("R10", "jalr ctrl", {21'd0, ctl_now()}, {21'd0, 11'b11000011_10_0});
        chk("R3", "jalr imm", imm_o, 32'hFFFFFFFF);
    endtask

    task automatic t_upper;
        apply({20'hABCDE, 5'd4, 7'b0110111});
        chk("R7", "lui imm", imm_o, 32'hABCDE000);
        chk("R8", "lui ctrl", {21'd0, ctl_now()}, {21'd0, 11'b11000000_11_0});
        apply({20'h00001, 5'd4, 7'b0010111});
        chk("R7", "auipc imm", imm_o, 32'h00001000);
        chk("R11", "auipc ctrl", {21'd0, ctl_now()}, {21'd0, 11'b11100000_00_0});
    endtask

    task automatic t_illegal;
        apply(32'hFFFFFFFF);
        chk("R2", "all ones", {21'd0, ctl_now()}, {21'd0, C_ILL});
        chk("R2", "all ones imm", imm_o, 32'd0);
        apply({20'hFFFFF, 5'd1, 7'b0110101}); // near-miss of load-upper
        chk("R2", "near lui", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(32'h0000000F);                  // fence opcode
        chk("R2", "fence", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(32'h00000073);                  // system opcode
        chk("R2", "system", {21'd0, ctl_now()}, {21'd0, C_ILL});
    endtask

    task automatic t_funct_rules;
        apply(enc_i(12'h004, 5'd1, 3'b000, 5'd2, 7'b0000011)); // byte load
        chk("R12", "lb", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_s(12'h004, 5'd1, 5'd2, 3'b001));             // half store
        chk("R12", "sh", {21'd0, ctl_now()}, {21'd0, C_ILL});
        chk("R12", "sh imm", imm_o, 32'd0);
        apply(enc_i(12'h004, 5'd1, 3'b001, 5'd2, 7'b1100111));
        chk("R12", "jalr f3", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_b(13'h0010, 3'b010));
        chk("R12", "branch f3 010", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_b(13'h0010, 3'b011));
        chk("R12", "branch f3 011", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b111, 5'd3));
        chk("R12", "alt and", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_r(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3));
        chk("R12", "mul", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_r(7'b0100000, 5'd2, 5'd1, 3'b101, 5'd3));
        chk("R12", "sra ok", {31'd0, illegal_o}, 32'd0);
        apply(enc_i({7'b0100000, 5'd3}, 5'd1, 3'b001, 5'd2, 7'b0010011));
        chk("R12", "slli alt", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_i({7'b0000001, 5'd3}, 5'd1, 3'b101, 5'd2, 7'b0010011));
        chk("R12", "srli bad f7", {21'd0, ctl_now()}, {21'd0, C_ILL});
        apply(enc_i(12'hFFF, 5'd1, 3'b111, 5'd2, 7'b0010011));
        chk("R12", "andi any imm", {31'd0, illegal_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset();
        t_fields();
        t_regreg();
        t_regimm();
        t_mem();
        t_branch();
        t_jumps();
        t_upper();
        t_illegal();
        t_funct_rules();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule